// File: doc/BRIEF.md
# Integer ALU with Condition Evaluator

This block is the purely combinational integer datapath of a 32-bit processor core. From two operands and an operation select it produces a result word, four status flags (zero, sign, overflow, carry) and a per-flag update mask. The register file commits the result when the write-enable output is high, and the status register latches only the flag bits whose mask bit is set.

Next to the datapath is a condition evaluator. It takes the current stored flags and a 4-bit condition code, and returns one taken bit. Conditional branches and set-on-condition operations consume this bit. The upper eight condition codes are the logical inverses of the lower eight.

Top module: `alu_core`

## Requirements
- R1: Operation code 0 (add) returns `a + b` modulo 2^32. Carry (flag bit 3) is set exactly when the unsigned result is below unsigned `a`. Overflow (flag bit 2) is set when `a` and `b` share a sign and the result's sign differs from it.
- R2: Operation code 1 (subtract) returns `a - b`. Carry is set as a borrow, exactly when the unsigned result exceeds unsigned `a`. Overflow is set when `a` and `b` differ in sign and the result's sign differs from that of `a`.
- R3: Operation code 2 (compare) produces the same four flags as subtract with the same mask. Write-enable stays low; it is high for every other defined operation.
- R4: Operation codes 3, 4, 5 and 6 return `a | b`, `a & b`, `a ^ b` and `~b`. Each clears overflow. Carry passes through from the flags input unchanged.
- R5: Shifts use only bits 4:0 of `b` as the amount. An amount of zero returns `a` unchanged and clears carry.
- R6: Operation code 7 (logical left shift) places in carry the last bit moved out past bit 31.
- R7: Operation codes 8 (logical right) and 9 (arithmetic right, sign-filling) place in carry the last bit moved out past bit 0.
- R8: Whenever zero (flag bit 0) and sign (flag bit 1) are updated, they show whether the result is all zeros and the value of the result's bit 31.
- R9: Condition codes 0 to 7 yield: overflow; carry; zero; carry or zero; sign; always 1; overflow xor sign; (overflow xor sign) or zero. The evaluation uses the flags input.
- R10: Condition codes 8 to 15 yield the inverse of the code with bit 3 cleared, so code 13 is never taken.
- R11: Operation codes 10 to 15 return result 0, mask 0, write-enable 0, and pass the flags input through to the flags output.
- R12: The update mask is 4'b1111 for add, subtract, compare and the three shifts, and 4'b0111 for the four bitwise operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Left operand; the value that is shifted |
| b_i | input | 32 | Right operand; bits 4:0 give the shift amount |
| op_i | input | 4 | Operation select (codes in R1 to R7, R11) |
| cond_i | input | 4 | Condition code for the evaluator |
| flags_i | input | 4 | Current flags {carry, overflow, sign, zero} |
| result_o | output | 32 | Operation result |
| flags_o | output | 4 | New flag values {carry, overflow, sign, zero} |
| flag_upd_o | output | 4 | Per-flag update mask, same bit order |
| wr_en_o | output | 1 | Result write-back enable |
| cond_true_o | output | 1 | Condition evaluator output |

## Verification
The bench drives the signed and unsigned edges 0x7FFFFFFF + 1, 0xFFFFFFFF + 1, 0x80000000 - 1 and 0 - 1. A design that took overflow or borrow from the wrong operand would show the wrong flag on exactly one of these. Shift amounts of 0, 31, 32 and 33 are applied. A shifter that used the full amount would zero the value, and one that missed the zero-amount case would leave a stale carry. Bitwise operations run with carry set on the input, so a design that cleared carry there is caught. Every condition code is tried against all sixteen flag patterns. A map that got the inversion wrong would take branches on code 13.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W = 32;
  localparam int NFLAG  = 4;
  localparam int FL_Z   = 0;
  localparam int FL_S   = 1;
  localparam int FL_OV  = 2;
  localparam int FL_CY  = 3;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_OR  = 4'd3,
    OP_AND = 4'd4,
    OP_XOR = 4'd5,
    OP_NOT = 4'd6,
    OP_SHL = 4'd7,
    OP_SHR = 4'd8,
    OP_SAR = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT = 2'd0,
    SH_RLOG = 2'd1,
    SH_RARI = 2'd2
  } sh_kind_e;

  // signed overflow of a sum: equal operand signs, result sign flipped
  function automatic logic add_ovf(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  // signed overflow of a difference: operand signs differ, result leaves a's sign
  function automatic logic sub_ovf(input logic sa, input logic sb, input logic sr);
    return (sa != sb) && (sr != sa);
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cy_o,
  output logic         ov_o
);
  import alu_pkg::*;

  logic [W:0] sum_w;
  logic [W:0] dif_w;

  assign sum_w = {1'b0, a_i} + {1'b0, b_i};
  assign dif_w = {1'b0, a_i} - {1'b0, b_i};

  always_comb begin
    if (sub_i) begin
      res_o = dif_w[W-1:0];
      cy_o  = dif_w[W];
      ov_o  = sub_ovf(a_i[W-1], b_i[W-1], dif_w[W-1]);
    end else begin
      res_o = sum_w[W-1:0];
      cy_o  = sum_w[W];
      ov_o  = add_ovf(a_i[W-1], b_i[W-1], sum_w[W-1]);
    end
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W   = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]    a_i,
  input  logic [SHW-1:0]  amt_i,
  input  alu_pkg::sh_kind_e kind_i,
  output logic [W-1:0]    res_o,
  output logic            cy_o,
  output logic            zero_amt_o
);
  import alu_pkg::*;

  // one guard bit beyond the word catches the last bit shifted out
  logic [W:0] left_w;
  logic [W:0] rlog_w;
  logic [W:0] rari_w;

  assign left_w = {1'b0, a_i} << amt_i;
  assign rlog_w = {a_i, 1'b0} >> amt_i;
  assign rari_w = $unsigned($signed({a_i, 1'b0}) >>> amt_i);
  assign zero_amt_o = (amt_i == '0);

  always_comb begin
    unique case (kind_i)
      SH_RLOG: begin res_o = rlog_w[W:1];   cy_o = rlog_w[0]; end
      SH_RARI: begin res_o = rari_w[W:1];   cy_o = rari_w[0]; end
      default: begin res_o = left_w[W-1:0]; cy_o = left_w[W]; end
    endcase
  end
endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval #(
  parameter int NCODE = 16,
  localparam int CW   = $clog2(NCODE),
  localparam int HALF = NCODE / 2
) (
  input  logic [3:0]    flags_i,
  input  logic [CW-1:0] code_i,
  output logic          taken_o
);
  import alu_pkg::*;

  logic [HALF-1:0]  base_w;
  logic [NCODE-1:0] map_w;
  logic ov_x_s;

  assign ov_x_s    = flags_i[FL_OV] ^ flags_i[FL_S];
  assign base_w[0] = flags_i[FL_OV];
  assign base_w[1] = flags_i[FL_CY];
  assign base_w[2] = flags_i[FL_Z];
  assign base_w[3] = flags_i[FL_CY] | flags_i[FL_Z];
  assign base_w[4] = flags_i[FL_S];
  assign base_w[5] = 1'b1;
  assign base_w[6] = ov_x_s;
  assign base_w[7] = ov_x_s | flags_i[FL_Z];

  // upper half of the map mirrors the lower half inverted
  for (genvar i = 0; i < NCODE; i++) begin : g_map
    if (i < HALF) begin : g_lo
      assign map_w[i] = base_w[i];
    end else begin : g_hi
      assign map_w[i] = ~base_w[i-HALF];
    end
  end

  assign taken_o = map_w[code_i];
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int W   = alu_pkg::DATA_W,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   op_i,
  input  logic [3:0]   cond_i,
  input  logic [3:0]   flags_i,
  output logic [W-1:0] result_o,
  output logic [3:0]   flags_o,
  output logic [3:0]   flag_upd_o,
  output logic         wr_en_o,
  output logic         cond_true_o
);
  import alu_pkg::*;

  alu_op_e  op_w;
  sh_kind_e sh_kind_w;
  logic         is_sub_w;
  logic [W-1:0] as_res_w;
  logic         as_cy_w;
  logic         as_ov_w;
  logic [W-1:0] sh_res_w;
  logic         sh_cy_w;
  logic         sh_zero_w;
  logic [W-1:0] lg_res_w;

  assign op_w     = alu_op_e'(op_i);
  assign is_sub_w = (op_w == OP_SUB) || (op_w == OP_CMP);

  always_comb begin
    unique case (op_w)
      OP_SHR:  sh_kind_w = SH_RLOG;
      OP_SAR:  sh_kind_w = SH_RARI;
      default: sh_kind_w = SH_LEFT;
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(is_sub_w),
    .res_o(as_res_w), .cy_o(as_cy_w), .ov_o(as_ov_w)
  );

  alu_shifter #(.W(W)) u_shift (
    .a_i(a_i), .amt_i(b_i[SHW-1:0]), .kind_i(sh_kind_w),
    .res_o(sh_res_w), .cy_o(sh_cy_w), .zero_amt_o(sh_zero_w)
  );

  alu_cond_eval #(.NCODE(16)) u_cond (
    .flags_i(flags_i), .code_i(cond_i), .taken_o(cond_true_o)
  );

  always_comb begin
    unique case (op_w)
      OP_OR:   lg_res_w = a_i | b_i;
      OP_AND:  lg_res_w = a_i & b_i;
      OP_XOR:  lg_res_w = a_i ^ b_i;
      default: lg_res_w = ~b_i;
    endcase
  end

  always_comb begin
    result_o   = '0;
    flags_o    = flags_i;
    flag_upd_o = '0;
    wr_en_o    = 1'b0;
    unique case (op_w)
      OP_ADD, OP_SUB, OP_CMP: begin
        result_o   = as_res_w;
        flags_o    = {as_cy_w, as_ov_w, as_res_w[W-1], as_res_w == '0};
        flag_upd_o = 4'b1111;
        wr_en_o    = (op_w != OP_CMP);
      end
      OP_OR, OP_AND, OP_XOR, OP_NOT: begin
        result_o   = lg_res_w;
        flags_o    = {flags_i[FL_CY], 1'b0, lg_res_w[W-1], lg_res_w == '0};
        flag_upd_o = 4'b0111;
        wr_en_o    = 1'b1;
      end
      OP_SHL, OP_SHR, OP_SAR: begin
        result_o   = sh_res_w;
        flags_o    = {sh_cy_w, 1'b0, sh_res_w[W-1], sh_res_w == '0};
        flag_upd_o = 4'b1111;
        wr_en_o    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a_i,
  input logic [3:0]   op_i,
  input logic [3:0]   cond_i,
  input logic [3:0]   flags_i,
  input logic [W-1:0] result_o,
  input logic [3:0]   flags_o,
  input logic [3:0]   flag_upd_o,
  input logic         wr_en_o,
  input logic         cond_true_o,
  input logic         sh_zero_w
);
  logic is_logic, is_shift;
  assign is_logic = (op_i >= 4'd3) && (op_i <= 4'd6);
  assign is_shift = (op_i >= 4'd7) && (op_i <= 4'd9);

  always_comb begin
    if (op_i == 4'd0)
      p_add_carry_r1: assert (flags_o[3] == (result_o < a_i));
    if (op_i == 4'd1 || op_i == 4'd2)
      p_sub_borrow_r2: assert (flags_o[3] == (result_o > a_i));
    if (op_i == 4'd2)
      p_cmp_no_write_r3: assert (!wr_en_o && flag_upd_o == 4'b1111);
    if (is_logic)
      p_logic_keep_carry_r4: assert (flags_o[3] == flags_i[3] && !flags_o[2] && !flag_upd_o[3]);
    if (is_shift && sh_zero_w)
      p_zero_shift_r5: assert (result_o == a_i && !flags_o[3]);
    if (flag_upd_o[0])
      p_zero_flag_r8: assert (flags_o[0] == (result_o == '0));
    if (flag_upd_o[1])
      p_sign_flag_r8: assert (flags_o[1] == result_o[W-1]);
    if (cond_i == 4'd13)
      p_never_code_r10: assert (!cond_true_o);
    if (cond_i == 4'd5)
      p_always_code_r9: assert (cond_true_o);
    if (op_i >= 4'd10)
      p_undef_op_r11: assert (flag_upd_o == 4'b0000 && !wr_en_o && flags_o == flags_i && result_o == '0);
  end
endmodule

bind alu_core alu_core_chk #(.W(W)) chk_i (
  .a_i(a_i), .op_i(op_i), .cond_i(cond_i), .flags_i(flags_i),
  .result_o(result_o), .flags_o(flags_o), .flag_upd_o(flag_upd_o),
  .wr_en_o(wr_en_o), .cond_true_o(cond_true_o), .sh_zero_w(sh_zero_w)
);

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] a, b, res;
  logic [3:0]  op, cond, fin, fout, mask;
  logic        wr, taken;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  alu_core dut_i (
    .a_i(a), .b_i(b), .op_i(op), .cond_i(cond), .flags_i(fin),
    .result_o(res), .flags_o(fout), .flag_upd_o(mask),
    .wr_en_o(wr), .cond_true_o(taken)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  fin;
    logic [31:0] res;
    logic [3:0]  fl;
    logic [3:0]  mk;
    logic        wr;
  } vec_t;

  typedef struct packed {
    logic [31:0] res;
    logic [3:0]  fl;
    logic [3:0]  mk;
    logic        wr;
  } exp_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 32'h7FFFFFFF, 32'h00000001, 4'h0, 32'h80000000, 4'h6, 4'hF, 1'b1},
    '{4'd0, 32'hFFFFFFFF, 32'h00000001, 4'h0, 32'h00000000, 4'h9, 4'hF, 1'b1},
    '{4'd1, 32'h80000000, 32'h00000001, 4'h0, 32'h7FFFFFFF, 4'h4, 4'hF, 1'b1},
    '{4'd1, 32'h00000000, 32'h00000001, 4'h0, 32'hFFFFFFFF, 4'hA, 4'hF, 1'b1},
    '{4'd2, 32'h00000005, 32'h00000005, 4'h0, 32'h00000000, 4'h1, 4'hF, 1'b0},
    '{4'd4, 32'hFFFFFFFF, 32'h80000000, 4'hF, 32'h80000000, 4'hA, 4'h7, 1'b1},
    '{4'd5, 32'h0F0F0F0F, 32'h0F0F0F0F, 4'h0, 32'h00000000, 4'h1, 4'h7, 1'b1},
    '{4'd6, 32'h12345678, 32'hFFFFFFFF, 4'h8, 32'h00000000, 4'h9, 4'h7, 1'b1},
    '{4'd3, 32'h00000001, 32'h80000000, 4'h0, 32'h80000001, 4'h2, 4'h7, 1'b1},
    '{4'd7, 32'h80000001, 32'h00000001, 4'h0, 32'h00000002, 4'h8, 4'hF, 1'b1},
    '{4'd7, 32'h00000001, 32'h00000020, 4'hF, 32'h00000001, 4'h0, 4'hF, 1'b1},
    '{4'd8, 32'h80000001, 32'h00000001, 4'h0, 32'h40000000, 4'h8, 4'hF, 1'b1},
    '{4'd9, 32'h80000000, 32'h0000001F, 4'h0, 32'hFFFFFFFF, 4'h2, 4'hF, 1'b1},
    '{4'd9, 32'h80000001, 32'h00000021, 4'h0, 32'hC0000000, 4'hA, 4'hF, 1'b1},
    '{4'd12, 32'h00000003, 32'h00000004, 4'h5, 32'h00000000, 4'h5, 4'h0, 1'b0},
    '{4'd8, 32'hFFFFFFFF, 32'h0000001F, 4'h0, 32'h00000001, 4'h8, 4'hF, 1'b1}
  };

  localparam logic [31:0] CORNERS [5] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};

  function automatic string op_tag(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3, 4'd4, 4'd5, 4'd6: return "R4";
      4'd7: return "R6";
      4'd8, 4'd9: return "R7";
      default: return "R11";
    endcase
  endfunction

  // reference model written from the requirements
  function automatic exp_t ref_alu(input logic [3:0] o, input logic [31:0] x,
                                   input logic [31:0] y, input logic [3:0] f);
    exp_t e;
    longint sx, sy, sr;
    logic [31:0] v;
    logic c;
    int n;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    e.res = 32'h0; e.fl = f; e.mk = 4'h0; e.wr = 1'b0;
    if (o <= 4'd2) begin
      if (o == 4'd0) begin
        v = x + y; sr = sx + sy; c = (v < x);
      end else begin
        v = x - y; sr = sx - sy; c = (v > x);
      end
      e.res = v; e.mk = 4'hF; e.wr = (o != 4'd2);
      e.fl = {c, (sr > 64'sd2147483647) || (sr < -64'sd2147483648), v[31], v == 32'h0};
    end else if (o <= 4'd6) begin
      case (o)
        4'd3: v = x | y;
        4'd4: v = x & y;
        4'd5: v = x ^ y;
        default: v = ~y;
      endcase
      e.res = v; e.mk = 4'h7; e.wr = 1'b1;
      e.fl = {f[3], 1'b0, v[31], v == 32'h0};
    end else if (o <= 4'd9) begin
      v = x; c = 1'b0; n = int'(y % 32);
      for (int k = 0; k < n; k++) begin
        if (o == 4'd7) begin c = v[31]; v = {v[30:0], 1'b0}; end
        else if (o == 4'd8) begin c = v[0]; v = {1'b0, v[31:1]}; end
        else begin c = v[0]; v = {v[31], v[31:1]}; end
      end
      e.res = v; e.mk = 4'hF; e.wr = 1'b1;
      e.fl = {c, 1'b0, v[31], v == 32'h0};
    end
    return e;
  endfunction

  function automatic logic ref_cond(input logic [3:0] c, input logic [3:0] f);
    logic z, s, ov, cy;
    z = f[0]; s = f[1]; ov = f[2]; cy = f[3];
    case (c)
      4'd0: return ov;          4'd8:  return !ov;
      4'd1: return cy;          4'd9:  return !cy;
      4'd2: return z;           4'd10: return !z;
      4'd3: return cy | z;      4'd11: return !(cy | z);
      4'd4: return s;           4'd12: return !s;
      4'd5: return 1'b1;        4'd13: return 1'b0;
      4'd6: return ov ^ s;      4'd14: return !(ov ^ s);
      default: return (ov ^ s) | z;
      4'd15: return !((ov ^ s) | z);
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] x,
                       input logic [31:0] y, input logic [3:0] f, input logic [3:0] c);
    @(negedge clk);
    op = o; a = x; b = y; fin = f; cond = c;
    #1;
  endtask

  task automatic run_ref(input logic [3:0] o, input logic [31:0] x,
                         input logic [31:0] y, input logic [3:0] f);
    exp_t e;
    apply(o, x, y, f, 4'd0);
    e = ref_alu(o, x, y, f);
    check(op_tag(o), "ref", {23'h0, res, fout, mask, wr}, {23'h0, e.res, e.fl, e.mk, e.wr});
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    exp_t e;
    logic [31:0] ra, rb;
    op = 4'd0; a = '0; b = '0; fin = '0; cond = 4'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset state: all-zero inputs give an add of zeros
    apply(4'd0, 32'h0, 32'h0, 4'h0, 4'd0);
    check("R8", "reset result", {32'h0, res}, 64'h0);
    check("R8", "reset flags", {60'h0, fout}, {60'h0, 4'h1});
    check("R12", "reset mask", {60'h0, mask}, {60'h0, 4'hF});

    // vector table
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].fin, 4'd0);
      check(op_tag(VECS[i].op), "table result", {32'h0, res}, {32'h0, VECS[i].res});
      check(op_tag(VECS[i].op), "table flags", {60'h0, fout}, {60'h0, VECS[i].fl});
      check("R12", "table mask", {60'h0, mask}, {60'h0, VECS[i].mk});
      check("R3", "table write enable", {63'h0, wr}, {63'h0, VECS[i].wr});
    end

    // zero-amount shift with a nonzero upper amount field
    apply(4'd8, 32'hA5A5A5A5, 32'hFFFFFFE0, 4'hF, 4'd0);
    check("R5", "shift by 32 result", {32'h0, res}, {32'h0, 32'hA5A5A5A5});
    check("R5", "shift by 32 carry", {63'h0, fout[3]}, 64'h0);

    // corner operands against the reference model
    for (int o = 0; o < 10; o++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run_ref(4'(o), CORNERS[i], CORNERS[j], 4'(i * 5 + j));

    // shift amounts 0..33 on corner values
    for (int o = 7; o < 10; o++)
      for (int n = 0; n < 34; n++)
        run_ref(4'(o), 32'h80000001 ^ 32'(n), 32'(n), 4'h8);

    // random operands, all operation codes including undefined ones
    void'($urandom(32'd1234));
    for (int k = 0; k < 400; k++) begin
      ra = $urandom;
      rb = (k % 3 == 0) ? ($urandom % 40) : $urandom;
      run_ref(4'($urandom % 16), ra, rb, 4'($urandom % 16));
    end

    // condition evaluator: every code against every flag pattern
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++) begin
        apply(4'd0, 32'h0, 32'h0, 4'(f), 4'(c));
        if (c < 8) check("R9", "condition", {63'h0, taken}, {63'h0, ref_cond(4'(c), 4'(f))});
        else       check("R10", "condition", {63'h0, taken}, {63'h0, ref_cond(4'(c), 4'(f))});
      end

    // condition reads flags_i, not the new flags of the current operation
    apply(4'd0, 32'h0, 32'h0, 4'h0, 4'd2);
    check("R9", "zero code uses input flags", {63'h0, taken}, 64'h0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule